// File: doc/BRIEF.md
# Video RAM Access Wait Controller

This controller sits between a processor and a video RAM that the display refresh logic also reads. A processor access that targets video RAM while the raster is in its visible region would disturb the picture. To prevent that, the controller stalls the processor by raising its WAIT line one master clock after the request. At that moment it captures the address, the write data and the direction. It then keeps WAIT raised until the display enters blanking. During blanking it drives one video RAM strobe of fixed length, and then it lets the processor continue.

A request that arrives while the display is already blanked gets the same strobe at once, with no stall. Only one access can be in flight at a time. After an access finishes, the controller ignores the request that is still held on the bus until the processor removes it, so the same access is never performed twice. Requests that do not select video RAM pass through without any effect.

Top module: `vram_wait_ctrl`

## Requirements
- R1: A video RAM request (`mem_req`, `vram_sel` and `mem_rd` or `mem_wr` all high) that arrives in idle while `disp_active` is high raises `cpu_wait` on the next clock edge.
- R2: Address, write data and direction are captured on the edge that accepts the request. During the strobe, `vram_addr` and `vram_wdata` show the captured values even if the processor bus changes afterwards.
- R3: While a stalled access waits for blanking, `cpu_wait` stays high and neither video RAM strobe is driven.
- R4: After `disp_active` falls, the pending access drives its strobe for exactly `STROBE_CYC` consecutive clocks. `cpu_wait` is low on the first clock after the strobe.
- R5: A video RAM request that arrives while `disp_active` is low never raises `cpu_wait`, and its strobe begins on the next clock edge.
- R6: For a read, `cpu_rdata` loads `vram_rdata` on the last strobe clock. It is valid when `cpu_wait` falls and holds its value until the next read completes.
- R7: After an access completes, a request still held on the bus is not accepted again until `mem_req` or `vram_sel` goes low.
- R8: A request with `vram_sel` low never raises `cpu_wait` or any video RAM strobe, whatever the state of `disp_active`.
- R9: While `rst_n` is low, `cpu_wait`, `vram_rd_en` and `vram_wr_en` are low, and any pending access is discarded. Reset release is synchronised internally over two clocks.
- R10: An access with `mem_wr` high drives only `vram_wr_en`; otherwise a read drives only `vram_rd_en`. The two strobes are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_req | input | 1 | Processor memory request, active high |
| mem_rd | input | 1 | Processor read strobe, active high |
| mem_wr | input | 1 | Processor write strobe, active high |
| vram_sel | input | 1 | Decoded video RAM address select |
| disp_active | input | 1 | High during the visible part of the raster |
| cpu_addr | input | ADDR_W | Processor address within video RAM |
| cpu_wdata | input | DATA_W | Processor write data |
| vram_rdata | input | DATA_W | Data returned by video RAM |
| cpu_wait | output | 1 | Processor stall request |
| vram_rd_en | output | 1 | Video RAM read strobe |
| vram_wr_en | output | 1 | Video RAM write strobe |
| vram_addr | output | ADDR_W | Captured address to video RAM |
| vram_wdata | output | DATA_W | Captured write data to video RAM |
| cpu_rdata | output | DATA_W | Read data captured for the processor |

## Verification
The bench builds the controller with `ADDR_W` = 4 and `STROBE_CYC` = 3. The small address space lets a bench-side memory model be written and read back at every location the vectors touch. The three-clock strobe separates correct counting from a hard-wired two-clock pulse. Vectors vary the direction, whether the display is active, and how long the stall lasts, from zero extra clocks to several. This covers the path that stalls, the path that does not, and corrupted bus values after capture.

// File: rtl/vram_wait_pkg.sv
package vram_wait_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_HOLD   = 2'd1,
    ST_STROBE = 2'd2,
    ST_DONE   = 2'd3
  } acc_state_t;

endpackage

// File: rtl/vram_rst_sync.sv
module vram_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/vram_wait_fsm.sv
module vram_wait_fsm
  import vram_wait_pkg::*;
#(
  parameter int STROBE_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic vram_req,
  input  logic disp_active,
  output logic accept,
  output logic strobe,
  output logic strobe_last,
  output logic cpu_wait
);

  localparam int CNT_W = (STROBE_CYC > 1) ? $clog2(STROBE_CYC) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STROBE_CYC - 1);

  acc_state_t       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             stalled_q, stalled_d;
  logic             cnt_en, stall_en;

  assign accept      = (state_q == ST_IDLE) && vram_req;
  assign strobe      = (state_q == ST_STROBE);
  assign strobe_last = strobe && (cnt_q == CNT_LAST);
  assign cpu_wait    = (state_q == ST_HOLD) || (strobe && stalled_q);

  always_comb begin
    state_d   = state_q;
    cnt_d     = cnt_q;
    stalled_d = stalled_q;
    cnt_en    = 1'b0;
    stall_en  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (vram_req) begin
          stall_en  = 1'b1;
          stalled_d = disp_active;
          cnt_en    = 1'b1;
          cnt_d     = '0;
          state_d   = disp_active ? ST_HOLD : ST_STROBE;
        end
      end
      ST_HOLD: begin
        if (!disp_active) state_d = ST_STROBE;
      end
      ST_STROBE: begin
        if (cnt_q == CNT_LAST) begin
          state_d = ST_DONE;
        end else begin
          cnt_en = 1'b1;
          cnt_d  = cnt_q + 1'b1;
        end
      end
      ST_DONE: begin
        if (!vram_req) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      stalled_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (cnt_en)   cnt_q     <= cnt_d;
      if (stall_en) stalled_q <= stalled_d;
    end
  end

endmodule

// File: rtl/vram_access_latch.sv
module vram_access_latch #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              is_wr,
  input  logic              rd_cap_en,
  input  logic [DATA_W-1:0] vram_rdata,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic              is_wr_q,
  output logic [DATA_W-1:0] rdata_q
);

  logic [ADDR_W-1:0] addr_d;
  logic [DATA_W-1:0] wdata_d;
  logic              is_wr_d;
  logic [DATA_W-1:0] rdata_d;

  always_comb begin
    addr_d  = cpu_addr;
    wdata_d = cpu_wdata;
    is_wr_d = is_wr;
    rdata_d = vram_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      is_wr_q <= 1'b0;
      rdata_q <= '0;
    end else begin
      if (cap_en) begin
        addr_q  <= addr_d;
        wdata_q <= wdata_d;
        is_wr_q <= is_wr_d;
      end
      if (rd_cap_en) rdata_q <= rdata_d;
    end
  end

endmodule

// File: rtl/vram_wait_ctrl.sv
module vram_wait_ctrl #(
  parameter int ADDR_W     = 10,
  parameter int DATA_W     = 8,
  parameter int STROBE_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mem_req,
  input  logic              mem_rd,
  input  logic              mem_wr,
  input  logic              vram_sel,
  input  logic              disp_active,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic [DATA_W-1:0] vram_rdata,
  output logic              cpu_wait,
  output logic              vram_rd_en,
  output logic              vram_wr_en,
  output logic [ADDR_W-1:0] vram_addr,
  output logic [DATA_W-1:0] vram_wdata,
  output logic [DATA_W-1:0] cpu_rdata
);

  logic rst_n_int;
  logic vram_req;
  logic accept;
  logic strobe;
  logic strobe_last;
  logic is_wr_q;

  assign vram_req = mem_req && vram_sel && (mem_rd || mem_wr);

  vram_rst_sync #(
    .STAGES(2)
  ) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  vram_wait_fsm #(
    .STROBE_CYC(STROBE_CYC)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n_int),
    .vram_req    (vram_req),
    .disp_active (disp_active),
    .accept      (accept),
    .strobe      (strobe),
    .strobe_last (strobe_last),
    .cpu_wait    (cpu_wait)
  );

  vram_access_latch #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_latch (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .cap_en     (accept),
    .cpu_addr   (cpu_addr),
    .cpu_wdata  (cpu_wdata),
    .is_wr      (mem_wr),
    .rd_cap_en  (strobe_last && !is_wr_q),
    .vram_rdata (vram_rdata),
    .addr_q     (vram_addr),
    .wdata_q    (vram_wdata),
    .is_wr_q    (is_wr_q),
    .rdata_q    (cpu_rdata)
  );

  assign vram_rd_en = strobe && !is_wr_q;
  assign vram_wr_en = strobe && is_wr_q;

endmodule

// File: rtl/vram_wait_chk.sv
module vram_wait_chk #(
  parameter int ADDR_W     = 10,
  parameter int DATA_W     = 8,
  parameter int STROBE_CYC = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_req,
  input logic              vram_sel,
  input logic              disp_active,
  input logic              cpu_wait,
  input logic              vram_rd_en,
  input logic              vram_wr_en,
  input logic [ADDR_W-1:0] vram_addr,
  input logic [DATA_W-1:0] vram_wdata
);

  localparam int LEN_W = $clog2(STROBE_CYC + 2);

  logic             any_strobe;
  logic [LEN_W-1:0] len_q;

  assign any_strobe = vram_rd_en || vram_wr_en;

  // length of the current strobe run, counted independently of the design
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          len_q <= '0;
    else if (any_strobe) len_q <= len_q + 1'b1;
    else                 len_q <= '0;
  end

  p_wait_cause_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_wait) |-> $past(mem_req && vram_sel && disp_active));

  p_capture_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (any_strobe && $past(any_strobe)) |-> ($stable(vram_addr) && $stable(vram_wdata)));

  p_strobe_in_blank_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(any_strobe) && $past(cpu_wait)) |-> $past(!disp_active));

  p_strobe_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(any_strobe) |-> (len_q == LEN_W'(STROBE_CYC)));

  p_release_after_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(any_strobe) |-> !cpu_wait);

  p_strobe_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({vram_rd_en, vram_wr_en}));

endmodule

bind vram_wait_ctrl vram_wait_chk #(
  .ADDR_W(ADDR_W),
  .DATA_W(DATA_W),
  .STROBE_CYC(STROBE_CYC)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .mem_req     (mem_req),
  .vram_sel    (vram_sel),
  .disp_active (disp_active),
  .cpu_wait    (cpu_wait),
  .vram_rd_en  (vram_rd_en),
  .vram_wr_en  (vram_wr_en),
  .vram_addr   (vram_addr),
  .vram_wdata  (vram_wdata)
);

// File: tb/vram_wait_ctrl_tb_top.sv
module vram_wait_ctrl_tb_top;

  localparam int AW = 4;
  localparam int DW = 8;
  localparam int SC = 3;
  localparam int NV = 8;

  logic          clk;
  logic          rst_n;
  logic          mem_req, mem_rd, mem_wr, vram_sel, disp_active;
  logic [AW-1:0] cpu_addr;
  logic [DW-1:0] cpu_wdata;
  logic [DW-1:0] vram_rdata;
  logic          cpu_wait, vram_rd_en, vram_wr_en;
  logic [AW-1:0] vram_addr;
  logic [DW-1:0] vram_wdata;
  logic [DW-1:0] cpu_rdata;

  int total = 0;
  int bad   = 0;
  bit ended = 0;

  logic [DW-1:0] ram   [0:(1<<AW)-1];
  logic [DW-1:0] shadow[0:(1<<AW)-1];

  // vector fields: {is_wr, addr[3:0], data[7:0], active, hold[3:0]}
  localparam logic [17:0] VEC [0:NV-1] = '{
    {1'b1, 4'h3, 8'hA5, 1'b1, 4'd2},
    {1'b0, 4'h3, 8'h00, 1'b1, 4'd0},
    {1'b1, 4'h7, 8'h3C, 1'b0, 4'd0},
    {1'b0, 4'h7, 8'h00, 1'b0, 4'd0},
    {1'b0, 4'h9, 8'h00, 1'b1, 4'd5},
    {1'b1, 4'hF, 8'hFF, 1'b1, 4'd1},
    {1'b0, 4'hF, 8'h00, 1'b1, 4'd3},
    {1'b1, 4'h0, 8'h01, 1'b0, 4'd0}
  };

  vram_wait_ctrl #(.ADDR_W(AW), .DATA_W(DW), .STROBE_CYC(SC)) dut_i (
    .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .vram_sel(vram_sel), .disp_active(disp_active),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .vram_rdata(vram_rdata),
    .cpu_wait(cpu_wait), .vram_rd_en(vram_rd_en), .vram_wr_en(vram_wr_en),
    .vram_addr(vram_addr), .vram_wdata(vram_wdata), .cpu_rdata(cpu_rdata)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // bench memory model: asynchronous read, write on clock edge
  assign vram_rdata = ram[vram_addr];
  always @(posedge clk) if (vram_wr_en) ram[vram_addr] <= vram_wdata;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic idle_bus();
    mem_req = 0; mem_rd = 0; mem_wr = 0; vram_sel = 0;
  endtask

  task automatic do_access(input bit wr, input logic [AW-1:0] a,
                           input logic [DW-1:0] d, input bit act, input int hold);
    mem_req = 1; vram_sel = 1; mem_wr = wr; mem_rd = !wr;
    cpu_addr = a; cpu_wdata = d; disp_active = act;
    @(negedge clk);
    // scramble the bus after capture (R2)
    cpu_addr = a ^ 4'h5; cpu_wdata = ~d;
    if (act) begin
      chk(cpu_wait === 1'b1, "R1 wait on active request", cpu_wait, 1);
      chk(!vram_rd_en && !vram_wr_en, "R3 no strobe while held", vram_rd_en | vram_wr_en, 0);
      for (int h = 0; h < hold; h++) begin
        @(negedge clk);
        chk(cpu_wait === 1'b1 && !vram_rd_en && !vram_wr_en, "R3 hold during active",
            {cpu_wait, vram_rd_en, vram_wr_en}, 3'b100);
      end
      disp_active = 0;
      @(negedge clk);
    end else begin
      chk(cpu_wait === 1'b0, "R5 no wait in blanking", cpu_wait, 0);
    end
    for (int k = 0; k < SC; k++) begin
      if (k > 0) @(negedge clk);
      chk(vram_wr_en === wr && vram_rd_en === !wr, "R10 strobe kind",
          {vram_rd_en, vram_wr_en}, {!wr, wr});
      chk(vram_addr === a, "R2 captured address", vram_addr, a);
      if (wr) chk(vram_wdata === d, "R2 captured data", vram_wdata, d);
      chk(cpu_wait === act, "R4 wait during strobe", cpu_wait, act);
    end
    @(negedge clk);
    chk(!vram_rd_en && !vram_wr_en, "R4 strobe length", {vram_rd_en, vram_wr_en}, 0);
    chk(cpu_wait === 1'b0, "R4 wait released", cpu_wait, 0);
    if (wr) shadow[a] = d;
    else    chk(cpu_rdata === shadow[a], "R6 read data", cpu_rdata, shadow[a]);
    idle_bus();
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 20000, 0);
    finish_run();
  end

  initial begin
    logic [DW-1:0] held;
    for (int i = 0; i < (1<<AW); i++) begin
      ram[i]    = DW'(i * 3 + 1);
      shadow[i] = DW'(i * 3 + 1);
    end
    idle_bus(); disp_active = 0; cpu_addr = '0; cpu_wdata = '0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk(!cpu_wait && !vram_rd_en && !vram_wr_en, "R9 reset outputs",
        {cpu_wait, vram_rd_en, vram_wr_en}, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);

    for (int v = 0; v < NV; v++)
      do_access(VEC[v][17], VEC[v][16:13], VEC[v][12:5], VEC[v][4], int'(VEC[v][3:0]));

    // R6: read result holds across a following write
    do_access(1'b0, 4'h3, '0, 1'b1, 1);
    held = cpu_rdata;
    do_access(1'b1, 4'h4, 8'h77, 1'b0, 0);
    chk(cpu_rdata === held, "R6 read data held over write", cpu_rdata, held);

    // R8: non-video request during active display
    mem_req = 1; vram_sel = 0; mem_wr = 1; disp_active = 1; cpu_wdata = 8'hEE;
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      chk(!cpu_wait && !vram_rd_en && !vram_wr_en, "R8 non-video ignored",
          {cpu_wait, vram_rd_en, vram_wr_en}, 0);
    end
    disp_active = 0;
    @(negedge clk);
    chk(!vram_wr_en, "R8 no deferred strobe", vram_wr_en, 0);
    idle_bus();
    @(negedge clk);

    // R7: request kept on the bus after completion is not accepted again
    mem_req = 1; vram_sel = 1; mem_wr = 1; mem_rd = 0; cpu_addr = 4'h2; cpu_wdata = 8'h5A;
    repeat (SC + 1) @(negedge clk);
    shadow[2] = 8'h5A;
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      chk(!vram_rd_en && !vram_wr_en && !cpu_wait, "R7 held request not re-accepted",
          {cpu_wait, vram_rd_en, vram_wr_en}, 0);
    end
    idle_bus();
    @(negedge clk);
    do_access(1'b0, 4'h2, '0, 1'b0, 0);

    // R9: reset discards a pending access
    mem_req = 1; vram_sel = 1; mem_wr = 1; mem_rd = 0; disp_active = 1;
    cpu_addr = 4'h6; cpu_wdata = 8'h99;
    @(negedge clk);
    chk(cpu_wait === 1'b1, "R1 wait before reset", cpu_wait, 1);
    rst_n = 0;
    #1;
    chk(cpu_wait === 1'b0, "R9 wait cleared by reset", cpu_wait, 0);
    idle_bus();
    @(negedge clk);
    rst_n = 1; disp_active = 0;
    for (int c = 0; c < 5; c++) begin
      @(negedge clk);
      chk(!vram_rd_en && !vram_wr_en && !cpu_wait, "R9 pending access dropped",
          {cpu_wait, vram_rd_en, vram_wr_en}, 0);
    end
    do_access(1'b0, 4'h6, '0, 1'b0, 0);

    finish_run();
  end

endmodule